// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Read Words

This block receives asynchronous serial characters on one input line. A fractional clock divider makes a sampling tick at sixteen times the bit rate. Each character is framed by a start bit, four to nine data bits sent least significant bit first, an optional parity bit and a stop bit. The receiver samples each bit near its centre. It places every finished character into a two-entry queue as a 16-bit word, and that word also carries the character's own parity and framing error bits.

Software enables and disables the receiver with a command write. It reads the head word and pops it with a strobe, and it watches a data-available output. Two interrupt flags exist: one marks a newly stored character and one marks a character that was lost because the queue was full. Each flag can be set, cleared and masked. A line break has no event of its own. It arrives as a word with the framing error set and every data bit zero.

Top module: `serial_rx_tagged`

## Requirements
- R1: The sampling tick fires on average once every (4 + cfg_div)/4 clock cycles, so one bit lasts 4*(4+cfg_div) cycles. Characters are received correctly for cfg_div values of 0, 1, 2 and 6.
- R2: cfg_bits selects 4 to 9 data bits, sent least significant bit first. The data goes into rd_word[8:0], and data bits above the configured width read 0. rd_word[13:9] is always 0.
- R3: cfg_par selects the parity mode: 2'b0x means no parity bit, 2'b10 means even and 2'b11 means odd. Parity is computed over the configured data bits only. A mismatch sets rd_word[14].
- R4: A low level at the first stop bit sets rd_word[15] and keeps the data. Only the first stop bit is checked, so a new start bit directly after one stop bit is received without error.
- R5: If the line is held low for a whole frame or longer, exactly one word is stored: framing error set and data zero (16'h8000 with no parity). No further character starts until the line has gone high and then falls again.
- R6: A start is detected on a high-to-low change of the line. If the line reads high at the start bit's midpoint (tick 8), the start is discarded and nothing is stored.
- R7: The queue holds 2 words in arrival order. rd_word shows the oldest word. A one-cycle rd_pop removes it, and a pop on an empty queue is ignored. rx_avail is high while at least one word is stored.
- R8: A character that completes while the queue is full is dropped, the stored words are kept, and interrupt flag bit 4 (overflow) is set.
- R9: Interrupt flag bit 2 (data valid) is set each time a character is stored. Only flag bits 2 and 4 exist; the other bits read 0.
- R10: Register writes use reg_we with reg_sel. Select 0 is the command: bit 0 enables the receiver and bit 1 disables it, and disable wins if both bits are set. Select 1 ORs reg_wdata into the flags, select 2 clears the flags where reg_wdata is 1, and select 3 loads the enable mask.
- R11: irq is a register that equals the OR of (irq_flags AND irq_en) from the previous cycle.
- R12: While the receiver is disabled, nothing is stored and no flag is set by the line.
- R13: After reset the receiver is disabled, the queue is empty, the flags and the enable mask are 0, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_rx | input | 1 | Serial input line, idle high |
| cfg_div | input | DIV_W | Fractional divider, tick period (4+cfg_div)/4 cycles |
| cfg_bits | input | 4 | Data bits per character (4..9, clamped) |
| cfg_par | input | 2 | Parity mode |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: command, flag set, flag clear, enable mask |
| reg_wdata | input | 5 | Register write data |
| rd_pop | input | 1 | Pops the head word |
| rd_word | output | 16 | Head word: ferr[15], perr[14], zero[13:9], data[8:0] |
| rx_avail | output | 1 | Queue not empty |
| rx_on | output | 1 | Receiver enabled |
| irq_flags | output | 5 | Interrupt flags (bit 2 valid, bit 4 overflow) |
| irq_en | output | 5 | Interrupt enable mask |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that cfg_div, cfg_bits and cfg_par stay constant while a frame is on the line, and that rd_pop is never raised in the same cycle as a character completes into a full queue. The bench changes configuration only while the line is idle, and it pops only after a frame has fully finished. The assertions also assume that bits of a word a neighbour decodes keep their positions. The stimulus therefore holds the line for whole multiples of the bit period computed from cfg_div, so every sample falls well inside its bit.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int WORD_W    = 16;
  localparam int DATA_MAX  = 9;
  localparam int PERR_BIT  = 14;
  localparam int FERR_BIT  = 15;
  localparam int FLAG_W    = 5;
  localparam int FLG_VALID = 2;
  localparam int FLG_OVF   = 4;

  typedef enum logic [1:0] {
    SEL_CMD = 2'd0,
    SEL_SET = 2'd1,
    SEL_CLR = 2'd2,
    SEL_IEN = 2'd3
  } reg_sel_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_t;
endpackage

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int ACC_W = DIV_W + 3;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] acc_inc;

  assign step    = ACC_W'(div) + ACC_W'(4);
  assign acc_inc = acc + ACC_W'(4);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (acc_inc >= step) begin
      acc  <= acc_inc - step;
      tick <= 1'b1;
    end else begin
      acc  <= acc_inc;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              rx,
  input  logic [3:0]        cfg_bits,
  input  logic [1:0]        cfg_par,
  output logic              push,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W    = $clog2(OVS);
  localparam int MID_CNT  = OVS / 2 - 2;
  localparam int LAST_CNT = OVS - 1;
  localparam int PAD_W    = WORD_W - 2 - DATA_MAX;

  rx_state_t           state;
  logic [CNT_W-1:0]    cnt;
  logic [3:0]          bidx;
  logic [3:0]          nb;
  logic [DATA_MAX-1:0] shreg;
  logic                par_acc;
  logic                perr;
  logic                line_prev;

  always_comb begin
    if (cfg_bits < 4'd4)      nb = 4'd4;
    else if (cfg_bits > 4'd9) nb = 4'd9;
    else                      nb = cfg_bits;
  end

  always_ff @(posedge clk) begin
    push <= 1'b0;
    if (rst || !en) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bidx      <= '0;
      shreg     <= '0;
      par_acc   <= 1'b0;
      perr      <= 1'b0;
      line_prev <= 1'b0;
      word      <= '0;
    end else if (tick) begin
      line_prev <= rx;
      cnt       <= cnt + 1'b1;
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (line_prev && !rx) state <= ST_START;
        end
        ST_START: begin
          if (cnt == CNT_W'(MID_CNT)) begin
            cnt <= '0;
            if (rx) begin
              state <= ST_IDLE;
            end else begin
              state   <= ST_DATA;
              bidx    <= '0;
              shreg   <= '0;
              par_acc <= 1'b0;
              perr    <= 1'b0;
            end
          end
        end
        ST_DATA: begin
          if (cnt == CNT_W'(LAST_CNT)) begin
            cnt         <= '0;
            shreg[bidx] <= rx;
            par_acc     <= par_acc ^ rx;
            bidx        <= bidx + 1'b1;
            if (bidx == nb - 4'd1) state <= cfg_par[1] ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: begin
          if (cnt == CNT_W'(LAST_CNT)) begin
            cnt   <= '0;
            perr  <= par_acc ^ rx ^ cfg_par[0];
            state <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (cnt == CNT_W'(LAST_CNT)) begin
            cnt   <= '0;
            push  <= 1'b1;
            word  <= {~rx, perr, {PAD_W{1'b0}}, shreg};
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr;
  logic [PTR_W-1:0] rptr;
  logic             do_wr;
  logic             do_rd;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CNT_W'(do_wr) - CNT_W'(do_rd);
    end
  end
endmodule

// File: rtl/serial_rx_tagged.sv
module serial_rx_tagged
  import srx_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int OVS        = 16,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_rx,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [3:0]        cfg_bits,
  input  logic [1:0]        cfg_par,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [FLAG_W-1:0] reg_wdata,
  input  logic              rd_pop,
  output logic [WORD_W-1:0] rd_word,
  output logic              rx_avail,
  output logic              rx_on,
  output logic [FLAG_W-1:0] irq_flags,
  output logic [FLAG_W-1:0] irq_en,
  output logic              irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [FLAG_W-1:0] IMPL =
    FLAG_W'((1 << FLG_VALID) | (1 << FLG_OVF));

  logic              rx_meta, rx_s;
  logic              tick;
  logic              frm_push;
  logic [WORD_W-1:0] frm_word;
  logic              fifo_full, fifo_empty;
  logic [CNT_W-1:0]  fifo_count;
  logic [FLAG_W-1:0] flags_n;
  reg_sel_t          sel;

  assign sel = reg_sel_t'(reg_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= line_rx;
      rx_s    <= rx_meta;
    end
  end

  srx_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk(clk), .rst(rst), .en(rx_on), .div(cfg_div), .tick(tick)
  );

  srx_frame #(.OVS(OVS)) i_frame (
    .clk(clk), .rst(rst), .en(rx_on), .tick(tick), .rx(rx_s),
    .cfg_bits(cfg_bits), .cfg_par(cfg_par),
    .push(frm_push), .word(frm_word)
  );

  srx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) i_fifo (
    .clk(clk), .rst(rst), .push(frm_push), .din(frm_word),
    .pop(rd_pop), .dout(rd_word), .full(fifo_full),
    .empty(fifo_empty), .count(fifo_count)
  );

  assign rx_avail = !fifo_empty;

  always_comb begin
    flags_n = irq_flags;
    if (reg_we && sel == SEL_SET) flags_n = flags_n | (reg_wdata & IMPL);
    if (reg_we && sel == SEL_CLR) flags_n = flags_n & ~reg_wdata;
    if (frm_push && !fifo_full)   flags_n[FLG_VALID] = 1'b1;
    if (frm_push && fifo_full)    flags_n[FLG_OVF]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_on     <= 1'b0;
      irq_flags <= '0;
      irq_en    <= '0;
      irq       <= 1'b0;
    end else begin
      irq_flags <= flags_n;
      irq       <= |(irq_flags & irq_en);
      if (reg_we && sel == SEL_IEN) irq_en <= reg_wdata & IMPL;
      if (reg_we && sel == SEL_CMD) begin
        if (reg_wdata[1])      rx_on <= 1'b0;
        else if (reg_wdata[0]) rx_on <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int CNT_W = 2,
  parameter int DEPTH = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_on,
  input logic             frame_push,
  input logic             fifo_full,
  input logic [CNT_W-1:0] fifo_count,
  input logic             rx_avail,
  input logic [15:0]      rd_word,
  input logic [4:0]       irq_flags,
  input logic [4:0]       irq_en,
  input logic             irq
);
  // R2: reserved bits of a stored word are zero
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rx_avail |-> rd_word[13:9] == 5'd0);

  // R7: occupancy never exceeds the queue depth
  p_depth_bound_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CNT_W'(DEPTH));

  // R8: a character arriving at a full queue raises overflow
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (frame_push && fifo_full) |=> irq_flags[4]);

  // R9: a newly stored character raises data valid
  p_valid_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (frame_push && !fifo_full) |=> (irq_flags[2] && rx_avail));

  // R9: unimplemented flag bits stay low
  p_flag_bits_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_flags & 5'b01011) == 5'd0);

  // R11: interrupt follows masked flags by one cycle
  p_irq_follow_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(|(irq_flags & irq_en)));

  // R12: a receiver that stayed disabled delivers nothing
  p_off_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (!rx_on && !$past(rx_on)) |-> !frame_push);
endmodule

bind serial_rx_tagged srx_checker #(
  .CNT_W($clog2(FIFO_DEPTH + 1)),
  .DEPTH(FIFO_DEPTH)
) i_chk (
  .clk(clk), .rst(rst), .rx_on(rx_on), .frame_push(frm_push),
  .fifo_full(fifo_full), .fifo_count(fifo_count), .rx_avail(rx_avail),
  .rd_word(rd_word), .irq_flags(irq_flags), .irq_en(irq_en), .irq(irq)
);

// File: tb/test_serial_rx_tagged.sv
module test_serial_rx_tagged;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_rx = 1'b1;
  logic [7:0]  cfg_div = 8'd0;
  logic [3:0]  cfg_bits = 4'd8;
  logic [1:0]  cfg_par = 2'b00;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [4:0]  reg_wdata = 5'd0;
  logic        rd_pop = 1'b0;
  logic [15:0] rd_word;
  logic        rx_avail, rx_on, irq;
  logic [4:0]  irq_flags, irq_en;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  serial_rx_tagged i_serial_rx_tagged (
    .clk(clk), .rst(rst), .line_rx(line_rx), .cfg_div(cfg_div),
    .cfg_bits(cfg_bits), .cfg_par(cfg_par), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rd_pop(rd_pop),
    .rd_word(rd_word), .rx_avail(rx_avail), .rx_on(rx_on),
    .irq_flags(irq_flags), .irq_en(irq_en), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bitc();
    return 4 * (4 + int'(cfg_div));
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [4:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    cyc(1);
    reg_we = 1'b0; reg_wdata = 5'd0;
    cyc(1);
  endtask

  task automatic pop();
    rd_pop = 1'b1;
    cyc(1);
    rd_pop = 1'b0;
    cyc(1);
  endtask

  function automatic logic [15:0] expect_word(input logic [8:0] d, input int nb,
                                              input bit perr, input bit ferr);
    logic [8:0] m;
    m = d & 9'((1 << nb) - 1);
    return {ferr, perr, 5'd0, m};
  endfunction

  task automatic send(input logic [8:0] d, input int nb, input logic [1:0] par,
                      input bit bad_par, input bit stop_v);
    logic p;
    int bc;
    bc = bitc();
    p = 1'b0;
    line_rx = 1'b0; cyc(bc);
    for (int i = 0; i < nb; i++) begin
      line_rx = d[i]; p = p ^ d[i]; cyc(bc);
    end
    if (par[1]) begin
      line_rx = p ^ par[0] ^ bad_par; cyc(bc);
    end
    line_rx = stop_v; cyc(bc);
    line_rx = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [8:0] d;
    cyc(4);
    rst = 1'b0;
    cyc(2);
    // R13 reset state
    check("R13 avail", {15'd0, rx_avail}, 16'd0);
    check("R13 on", {15'd0, rx_on}, 16'd0);
    check("R13 flags", {11'd0, irq_flags}, 16'd0);
    check("R13 ien", {11'd0, irq_en}, 16'd0);
    check("R13 irq", {15'd0, irq}, 16'd0);

    // R12 disabled receiver ignores the line
    send(9'h5A, 8, 2'b00, 1'b0, 1'b1); cyc(4);
    check("R12 avail", {15'd0, rx_avail}, 16'd0);
    check("R12 flags", {11'd0, irq_flags}, 16'd0);

    // R10 enable command
    wr(2'd0, 5'b00001); cyc(4);
    check("R10 enable", {15'd0, rx_on}, 16'd1);

    // R7 pop on empty queue ignored
    pop();
    check("R7 empty pop", {15'd0, rx_avail}, 16'd0);

    // R1 R2 exhaustive 8-bit sweep without parity
    for (int v = 0; v < 256; v++) begin
      send(9'(v), 8, 2'b00, 1'b0, 1'b1); cyc(2);
      check("R2 8N word", rd_word, expect_word(9'(v), 8, 1'b0, 1'b0));
      check("R7 avail", {15'd0, rx_avail}, 16'd1);
      pop();
    end
    check("R7 drained", {15'd0, rx_avail}, 16'd0);

    // R2 R3 widths 4..9 with every parity mode, injected parity errors
    for (int nb = 4; nb <= 9; nb++) begin
      for (int pm = 0; pm < 3; pm++) begin
        cfg_bits = 4'(nb);
        cfg_par  = (pm == 0) ? 2'b00 : ((pm == 1) ? 2'b10 : 2'b11);
        cyc(2);
        for (int k = 0; k < 8; k++) begin
          bit bad;
          d = 9'((k * 97 + nb * 13 + pm * 5) & 511);
          bad = (pm != 0) && k[0];
          send(d, nb, cfg_par, bad, 1'b1); cyc(2);
          check("R3 width/parity", rd_word, expect_word(d, nb, bad, 1'b0));
          pop();
        end
      end
    end
    cfg_bits = 4'd8; cfg_par = 2'b00; cyc(2);

    // R4 framing error keeps data
    send(9'hA5, 8, 2'b00, 1'b0, 1'b0); cyc(bitc());
    check("R4 ferr", rd_word, expect_word(9'hA5, 8, 1'b0, 1'b1));
    pop();

    // R4 back to back frames after one stop bit
    send(9'h3C, 8, 2'b00, 1'b0, 1'b1);
    send(9'hC3, 8, 2'b00, 1'b0, 1'b1); cyc(2);
    check("R4 first", rd_word, expect_word(9'h3C, 8, 1'b0, 1'b0));
    pop();
    check("R4 second", rd_word, expect_word(9'hC3, 8, 1'b0, 1'b0));
    pop();

    // R5 break
    line_rx = 1'b0; cyc(bitc() * 14);
    line_rx = 1'b1; cyc(bitc() * 2);
    check("R5 break word", rd_word, 16'h8000);
    pop();
    check("R5 single word", {15'd0, rx_avail}, 16'd0);

    // R6 start glitch discarded
    line_rx = 1'b0; cyc(4);
    line_rx = 1'b1; cyc(bitc() * 12);
    check("R6 glitch", {15'd0, rx_avail}, 16'd0);

    // R9 R10 R11 flags and interrupt
    wr(2'd2, 5'b11111);
    wr(2'd3, 5'b00100);
    check("R10 ien", {11'd0, irq_en}, 16'h0004);
    send(9'h11, 8, 2'b00, 1'b0, 1'b1); cyc(3);
    check("R9 valid flag", {11'd0, irq_flags}, 16'h0004);
    check("R11 irq high", {15'd0, irq}, 16'd1);
    pop();
    wr(2'd2, 5'b00100); cyc(1);
    check("R10 clear", {11'd0, irq_flags}, 16'd0);
    check("R11 irq low", {15'd0, irq}, 16'd0);
    wr(2'd1, 5'b11111); cyc(1);
    check("R9 set only impl", {11'd0, irq_flags}, 16'h0014);
    wr(2'd2, 5'b11111);
    send(9'h22, 8, 2'b00, 1'b0, 1'b1); cyc(2);
    check("R9 valid again", {11'd0, irq_flags}, 16'h0004);
    pop();
    wr(2'd2, 5'b11111);

    // R8 overflow
    send(9'h01, 8, 2'b00, 1'b0, 1'b1);
    send(9'h02, 8, 2'b00, 1'b0, 1'b1);
    send(9'h03, 8, 2'b00, 1'b0, 1'b1); cyc(2);
    check("R8 ovf flag", {11'd0, irq_flags}, 16'h0014);
    check("R8 kept first", rd_word, 16'h0001);
    pop();
    check("R8 kept second", rd_word, 16'h0002);
    pop();
    check("R8 third dropped", {15'd0, rx_avail}, 16'd0);
    wr(2'd3, 5'b10000); cyc(1);
    check("R11 ovf irq", {15'd0, irq}, 16'd1);
    wr(2'd3, 5'b00000);
    wr(2'd2, 5'b11111);

    // R1 fractional divider values
    for (int dv = 0; dv < 3; dv++) begin
      cfg_div = (dv == 0) ? 8'd1 : ((dv == 1) ? 8'd2 : 8'd6);
      for (int k = 0; k < 4; k++) begin
        d = 9'((k * 71 + dv * 29 + 3) & 255);
        cfg_bits = 4'd8; cfg_par = 2'b00; cyc(2);
        send(d, 8, 2'b00, 1'b0, 1'b1); cyc(4);
        check("R1 frac 8N", rd_word, expect_word(d, 8, 1'b0, 1'b0));
        pop();
        cfg_bits = 4'd7; cfg_par = 2'b10; cyc(2);
        send(d, 7, 2'b10, 1'b0, 1'b1); cyc(4);
        check("R1 frac 7E", rd_word, expect_word(d, 7, 1'b0, 1'b0));
        pop();
      end
    end
    cfg_div = 8'd0; cfg_bits = 4'd8; cfg_par = 2'b00; cyc(2);

    // R10 disable wins, R12 nothing stored afterwards
    wr(2'd0, 5'b00011); cyc(1);
    check("R10 disable wins", {15'd0, rx_on}, 16'd0);
    wr(2'd2, 5'b11111);
    send(9'h77, 8, 2'b00, 1'b0, 1'b1); cyc(4);
    check("R12 off avail", {15'd0, rx_avail}, 16'd0);
    check("R12 off flags", {11'd0, irq_flags}, 16'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule